// File: doc/BRIEF.md
# TRNG Sampling and Conditioning Pipeline

This block turns a raw, asynchronous entropy bit into conditioned 32-bit random words. It delivers those words into a separate pool for each host. The raw bit comes from one of two inputs: the on-chip ring-oscillator output or an external entropy line. It is brought into the clock domain through two flip-flops. It is then sampled at a slower rate, set by a programmable divider.

Each sample pair goes through a von Neumann debiaser. Every surviving bit is XORed with a free-running 32-bit LFSR sequence and shifted into a word. A continuous repetition test compares every finished word against the word before it. A repeat raises a sticky failure flag and freezes pool filling until the privileged host clears it.

Accepted words are dealt round-robin into small per-host FIFOs. Each host pulls its words through its own request/valid read port. Configuration writes take effect only when the privileged-host qualifier is high.

Top module: `trng_conditioner`

## Requirements
- R1: Source select: `cfg_src_ext`=1 selects `ext_bit` and 0 selects `ring_bit`. Reset selects `ring_bit`.
- R2: Sampling: after an accepted configuration write, one sample of the selected source is taken every `cfg_div`+1 clock cycles. Each sample is the value the source had two clock edges before the sampling edge.
- R3: A write with `cfg_we`=1 and `cfg_priv`=1 is accepted. It loads source, divider and clear, and it restarts the sample counter, the pair phase and the partial word. A write with `cfg_priv`=0 has no effect on any of these or on `fail`.
- R4: Debiasing: samples form non-overlapping pairs, counted from the first sample after an accepted write. The pair (0 then 1) yields 0, the pair (1 then 0) yields 1, and the pairs 00 and 11 yield nothing.
- R5: Mixing: each debiased bit is XORed with bit 31 of an LFSR. The LFSR resets to 32'h0000_0001 and advances after every debiased bit to {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R6: Word assembly: 32 mixed bits make one word. Each bit shifts in at bit 0, so the first bit of a word ends up in bit 31.
- R7: Continuous test: a finished word equal to the previous finished word is rejected and sets `fail`. The first word after reset is accepted.
- R8: `fail` is sticky, and while it is set no word enters any pool. Only an accepted write with `cfg_clr`=1 clears it.
- R9: Accepted words go round-robin to hosts 0,1,... starting at host 0 after reset. A word aimed at a full pool is dropped and the pointer still advances.
- R10: Each pool is a FIFO of DEPTH words, read back in arrival order.
- R11: A one-cycle `rd_req[h]` gives, on the next cycle, `rd_valid[h]`=1 with the oldest word of pool h. If the pool is empty it gives `rd_valid[h]`=0 and zero data.
- R12: After reset all pools are empty and `fail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_bit | input | 1 | Ring-oscillator entropy bit (asynchronous) |
| ext_bit | input | 1 | External entropy bit (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Write comes from the privileged host |
| cfg_src_ext | input | 1 | Source select value to write |
| cfg_div | input | DIV_W | Sample divider value to write |
| cfg_clr | input | 1 | Clear the failure flag with this write |
| rd_req | input | N_HOST | Per-host pool read request |
| rd_valid | output | N_HOST | Per-host read data valid |
| rd_data | output | N_HOST*32 | Per-host read word, host h at bits h*32 +: 32 |
| fail | output | 1 | Sticky continuous-test failure |

## Verification
The bench chooses each target word and drives the raw pair pattern that must produce it through the debiaser and the LFSR. The word is therefore seen only if pair alignment, pair polarity, keystream and bit order are all right.

The same words are sent at divider 0 and divider 3, and through each source, to separate rate and source errors. Back-to-back identical words and a stream past pool depth expose continuous-test, sticky-flag, dealing and drop faults. Unprivileged writes, including one landing mid-stream and one trying to clear the flag, show that the configuration is left untouched.

// File: rtl/trng_pkg.sv
package trng_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] LFSR_SEED = 32'h0000_0001;

    // Taps 32,22,2,1
    function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
        return {s[WORD_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction
endpackage

// File: rtl/trng_sampler.sv
module trng_sampler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring_bit,
    input  logic             ext_bit,
    input  logic             src_ext,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             smp_valid,
    output logic             smp_bit
);
    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic [DIV_W-1:0] cnt;
        logic             smp_v;
        logic             smp_b;
    } smp_state_t;

    smp_state_t q, d;

    always_comb begin
        d       = q;
        d.sync1 = src_ext ? ext_bit : ring_bit;
        d.sync2 = q.sync1;
        d.smp_v = 1'b0;
        if (restart) begin
            d.cnt = '0;
        end else if (q.cnt == div) begin
            d.cnt   = '0;
            d.smp_v = 1'b1;
            d.smp_b = q.sync2;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign smp_valid = q.smp_v;
    assign smp_bit   = q.smp_b;

    // R2
    rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && div != '0) |=> !smp_valid);
endmodule

// File: rtl/trng_debias_mix.sv
module trng_debias_mix
    import trng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_bit,
    input  logic              restart,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic              phase;
        logic              first;
        logic [WORD_W-1:0] lfsr;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              wv;
    } dm_state_t;

    dm_state_t q, d;

    always_comb begin
        d    = q;
        d.wv = 1'b0;
        if (restart) begin
            d.phase = 1'b0;
            d.cnt   = '0;
        end else if (smp_valid) begin
            if (!q.phase) begin
                d.first = smp_bit;
                d.phase = 1'b1;
            end else begin
                d.phase = 1'b0;
                if (q.first != smp_bit) begin
                    d.shreg = {q.shreg[WORD_W-2:0], q.first ^ q.lfsr[WORD_W-1]};
                    d.lfsr  = lfsr_step(q.lfsr);
                    if (q.cnt == CNT_W'(WORD_W - 1)) begin
                        d.cnt = '0;
                        d.wv  = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.lfsr <= LFSR_SEED;
        end else begin
            q <= d;
        end
    end

    assign word_valid = q.wv;
    assign word       = q.shreg;

    // R6
    word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);
endmodule

// File: rtl/trng_crt.sv
module trng_crt
    import trng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    input  logic              clr,
    output logic              acc_valid,
    output logic [WORD_W-1:0] acc_word,
    output logic              fail
);
    typedef struct packed {
        logic [WORD_W-1:0] prev_w;
        logic              have_prev;
        logic              fail;
        logic              av;
        logic [WORD_W-1:0] aw;
    } crt_state_t;

    crt_state_t q, d;

    always_comb begin
        d    = q;
        d.av = 1'b0;
        if (clr) d.fail = 1'b0;
        if (word_valid) begin
            if (q.have_prev && word == q.prev_w) begin
                d.fail = 1'b1;
            end else if (!d.fail) begin
                d.av = 1'b1;
                d.aw = word;
            end
            d.prev_w    = word;
            d.have_prev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign acc_valid = q.av;
    assign acc_word  = q.aw;
    assign fail      = q.fail;

    // R7
    repeat_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && q.have_prev && word == q.prev_w) |=> (fail && !acc_valid));
    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> (fail && !acc_valid));
endmodule

// File: rtl/trng_pool.sv
module trng_pool
    import trng_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [AW:0]                  wp;
        logic [AW:0]                  rp;
        logic                         rv;
        logic [WORD_W-1:0]            rd;
    } pool_state_t;

    pool_state_t q, d;
    logic        empty, full;

    always_comb begin
        empty = (q.wp == q.rp);
        full  = (q.wp[AW] != q.rp[AW]) && (q.wp[AW-1:0] == q.rp[AW-1:0]);
        d     = q;
        d.rv  = 1'b0;
        d.rd  = '0;
        if (rd_req && !empty) begin
            d.rv = 1'b1;
            d.rd = q.mem[q.rp[AW-1:0]];
            d.rp = q.rp + 1'b1;
        end
        if (push && !full) begin
            d.mem[q.wp[AW-1:0]] = push_data;
            d.wp                = q.wp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_valid = q.rv;
    assign rd_data  = q.rd;

    // R11
    rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_req) |=> $stable(q.wp));
endmodule

// File: rtl/trng_conditioner.sv
module trng_conditioner
    import trng_pkg::*;
#(
    parameter int N_HOST = 2,
    parameter int DEPTH  = 4,
    parameter int DIV_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ring_bit,
    input  logic                     ext_bit,
    input  logic                     cfg_we,
    input  logic                     cfg_priv,
    input  logic                     cfg_src_ext,
    input  logic [DIV_W-1:0]         cfg_div,
    input  logic                     cfg_clr,
    input  logic [N_HOST-1:0]        rd_req,
    output logic [N_HOST-1:0]        rd_valid,
    output logic [N_HOST*WORD_W-1:0] rd_data,
    output logic                     fail
);
    localparam int HOST_W = (N_HOST > 1) ? $clog2(N_HOST) : 1;

    typedef struct packed {
        logic              src_ext;
        logic [DIV_W-1:0]  div;
        logic [HOST_W-1:0] rr;
    } top_state_t;

    top_state_t q, d;

    logic              accept, clr;
    logic              smp_valid, smp_bit;
    logic              word_valid;
    logic [WORD_W-1:0] word;
    logic              acc_valid;
    logic [WORD_W-1:0] acc_word;
    logic [N_HOST-1:0] push;

    assign accept = cfg_we && cfg_priv;
    assign clr    = accept && cfg_clr;

    always_comb begin
        d = q;
        if (accept) begin
            d.src_ext = cfg_src_ext;
            d.div     = cfg_div;
        end
        if (acc_valid) begin
            if (q.rr == HOST_W'(N_HOST - 1)) d.rr = '0;
            else                             d.rr = q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    trng_sampler #(.DIV_W(DIV_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ring_bit(ring_bit), .ext_bit(ext_bit),
        .src_ext(q.src_ext), .div(q.div), .restart(accept),
        .smp_valid(smp_valid), .smp_bit(smp_bit)
    );

    trng_debias_mix u_mix (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bit(smp_bit),
        .restart(accept), .word_valid(word_valid), .word(word)
    );

    trng_crt u_crt (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
        .clr(clr), .acc_valid(acc_valid), .acc_word(acc_word), .fail(fail)
    );

    for (genvar h = 0; h < N_HOST; h++) begin : g_pool
        assign push[h] = acc_valid && (q.rr == HOST_W'(h));
        trng_pool #(.DEPTH(DEPTH)) u_pool (
            .clk(clk), .rst_n(rst_n), .push(push[h]), .push_data(acc_word),
            .rd_req(rd_req[h]), .rd_valid(rd_valid[h]),
            .rd_data(rd_data[h*WORD_W +: WORD_W])
        );
    end

    // R3
    priv_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> ($stable(q.src_ext) && $stable(q.div)));
    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push));
endmodule

// File: tb/tb_trng_conditioner.sv
module tb_trng_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ring_bit = 1'b0, ext_bit = 1'b0;
    logic          cfg_we = 1'b0, cfg_priv = 1'b0, cfg_src_ext = 1'b0, cfg_clr = 1'b0;
    logic [7:0]    cfg_div = '0;
    logic [NH-1:0] rd_req = '0;
    logic [NH-1:0] rd_valid;
    logic [NH*32-1:0] rd_data;
    logic          fail;

    int   vectors = 0, miscompares = 0;
    bit   done = 1'b0;
    logic [31:0] lfsr_m = 32'h0000_0001;
    bit   src_m = 1'b0;
    int   div_m = 0;
    logic [31:0] wbuf [10];

    always #(CLK_PERIOD/2) clk = ~clk;

    trng_conditioner #(.N_HOST(NH), .DEPTH(4), .DIV_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .ring_bit(ring_bit), .ext_bit(ext_bit),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_src_ext(cfg_src_ext),
        .cfg_div(cfg_div), .cfg_clr(cfg_clr), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .fail(fail)
    );

    // R5 keystream model
    function automatic logic [31:0] step_m(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic configure(input bit ext, input int div, input bit clr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_src_ext = ext;
        cfg_div = div[7:0]; cfg_clr = clr;
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0; cfg_clr = 1'b0;
        src_m = ext; div_m = div;
    endtask

    task automatic drive_line(input bit v);
        if (src_m) ext_bit = v; else ring_bit = v;
        repeat (div_m + 1) @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0; cfg_clr = 1'b0;
    endtask

    // R4 R5 R6: raw pairs chosen so the conditioned word equals w
    task automatic send_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            logic b;
            b = w[i] ^ lfsr_m[31];
            lfsr_m = step_m(lfsr_m);
            if (b) begin drive_line(1'b1); drive_line(1'b0); end
            else   begin drive_line(1'b0); drive_line(1'b1); end
        end
    endtask

    task automatic stream(input bit ext, input int div, input bit intrude, input int n);
        configure(ext, div, 1'b0);
        if (intrude) begin
            cfg_we = 1'b1; cfg_priv = 1'b0; cfg_src_ext = ~ext;
            cfg_div = 8'd5; cfg_clr = 1'b1;
        end
        for (int i = 0; i < n; i++) send_word(wbuf[i]);
        ring_bit = 1'b0; ext_bit = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic read_chk(input int h, input bit ev, input logic [31:0] ed, input string tag);
        logic        v;
        logic [31:0] dt;
        @(negedge clk);
        rd_req[h] = 1'b1;
        @(negedge clk);
        rd_req[h] = 1'b0;
        v  = rd_valid[h];
        dt = rd_data[h*32 +: 32];
        vectors++;
        if (v !== ev || (ev && dt !== ed) || (!ev && dt !== 32'h0)) begin
            miscompares++;
            $display("FAIL %s host%0d: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, h, v, dt, ev, ev ? ed : 32'h0);
        end
    endtask

    task automatic fail_chk(input bit ef, input string tag);
        vectors++;
        if (fail !== ef) begin
            miscompares++;
            $display("FAIL %s: fail=%0b expected %0b", tag, fail, ef);
        end
    endtask

    task automatic t_reset;
        fail_chk(1'b0, "R12 reset flag");
        read_chk(0, 1'b0, 32'h0, "R12 R11 empty after reset");
        read_chk(1, 1'b0, 32'h0, "R12 R11 empty after reset");
    endtask

    task automatic t_ext_fast;
        wbuf[0] = 32'h1234_5678; wbuf[1] = 32'hFFFF_0000;
        wbuf[2] = 32'h0000_0001; wbuf[3] = 32'h8000_0000;
        stream(1'b1, 0, 1'b1, 4);
        read_chk(0, 1'b1, 32'h1234_5678, "R1 R3 R4 R5 R6 R9 host0 first");
        read_chk(0, 1'b1, 32'h0000_0001, "R9 R10 host0 second");
        read_chk(1, 1'b1, 32'hFFFF_0000, "R9 host1 first");
        read_chk(1, 1'b1, 32'h8000_0000, "R10 host1 second");
        read_chk(0, 1'b0, 32'h0, "R11 host0 drained");
        fail_chk(1'b0, "R3 unprivileged clear attempt left flag");
    endtask

    task automatic t_ext_slow;
        wbuf[0] = 32'hDEAD_BEEF; wbuf[1] = 32'hCAFE_F00D;
        stream(1'b1, 3, 1'b0, 2);
        read_chk(0, 1'b1, 32'hDEAD_BEEF, "R2 divider 3 host0");
        read_chk(1, 1'b1, 32'hCAFE_F00D, "R2 divider 3 host1");
    endtask

    task automatic t_ring;
        wbuf[0] = 32'h0F0F_A5A5; wbuf[1] = 32'h7777_1111;
        ext_bit = 1'b1;
        stream(1'b0, 0, 1'b0, 2);
        ext_bit = 1'b0;
        read_chk(0, 1'b1, 32'h0F0F_A5A5, "R1 ring source host0");
        read_chk(1, 1'b1, 32'h7777_1111, "R1 ring source host1");
    endtask

    task automatic t_repeat;
        wbuf[0] = 32'h5555_AAAA; wbuf[1] = 32'h5555_AAAA; wbuf[2] = 32'h1357_9BDF;
        stream(1'b1, 0, 1'b0, 3);
        fail_chk(1'b1, "R7 repeated word sets flag");
        read_chk(0, 1'b1, 32'h5555_AAAA, "R7 first copy accepted");
        read_chk(0, 1'b0, 32'h0, "R7 repeat rejected");
        read_chk(1, 1'b0, 32'h0, "R8 no fill while failed");
    endtask

    task automatic t_clear;
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b0; cfg_clr = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_clr = 1'b0;
        fail_chk(1'b1, "R3 R8 unprivileged clear ignored");
        configure(1'b1, 0, 1'b1);
        fail_chk(1'b0, "R8 privileged clear");
        wbuf[0] = 32'h2468_ACE0;
        stream(1'b1, 0, 1'b0, 1);
        read_chk(1, 1'b1, 32'h2468_ACE0, "R8 R9 fill resumes at host1");
        read_chk(0, 1'b0, 32'h0, "R9 host0 untouched");
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 10; i++) wbuf[i] = 32'h3C00_0000 + i * 32'h0101_0101;
        stream(1'b1, 0, 1'b0, 10);
        for (int i = 0; i < 4; i++) read_chk(0, 1'b1, wbuf[2*i], "R10 R9 host0 order");
        read_chk(0, 1'b0, 32'h0, "R9 full pool dropped word");
        for (int i = 0; i < 4; i++) read_chk(1, 1'b1, wbuf[2*i+1], "R10 host1 order");
        read_chk(1, 1'b0, 32'h0, "R9 full pool dropped word");
        fail_chk(1'b0, "R7 distinct words pass");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ext_fast;
        t_ext_slow;
        t_ring;
        t_repeat;
        t_clear;
        t_overflow;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule